// File: doc/BRIEF.md
# Soft-Stepping Record Gain Ramp

This block sets the gain code for one record channel. Software or a control loop programs a target gain in half-decibel units. The block does not jump straight to a new target. It walks the applied gain toward the target one code at a time. Each step waits for a step interval of one or two output-sample strobes, which keeps the gain change smooth. Soft stepping can be turned off. The applied gain then jumps to the target at the next strobe.

Mute is a distinct state that sits one step below code 0. The block leaves reset in mute. A power-down request makes the gain ramp down step by step into mute. Only once mute is reached does the block report the channel as powered down. When the request is released, the ramp climbs from mute back toward the programmed target. A flag shows when the applied gain equals the target.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: Gain codes run from 0 to 119, where each code is 0.5 dB. A target above 119 is treated as 119.
- R2: After a synchronous reset the outputs are `muted`=1, `gain_code`=0, `at_target`=0 and `pdn_done`=0.
- R3: With soft stepping on and `interval_two`=0, each `sample_stb` moves the applied gain exactly one step toward the goal. Without a strobe the gain never changes.
- R4: With soft stepping on and `interval_two`=1, a step happens only on every second strobe. The strobe-pair counter clears whenever the applied gain equals the goal.
- R5: The step up from mute lands on code 0 with `muted`=0. The step down from code 0 enters mute (`muted`=1, `gain_code`=0).
- R6: With soft stepping off, the applied gain takes the goal value on the next strobe. This holds whether the goal is a code or mute.
- R7: While `pdn_req`=1 the goal is mute. `pdn_done` rises one clock after mute is reached and stays high while the request is held. It clears one clock after release, and the ramp then resumes from mute toward the target.
- R8: `at_target` is 1 exactly when the block is not muted and `gain_code` equals the clamped target.
- R9: If the target moves during a ramp, the direction is chosen again at every step. The gain never passes the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| target_code | input | 7 | Programmed gain target, 0.5 dB per code |
| sample_stb | input | 1 | One-clock strobe per output sample |
| interval_two | input | 1 | 1: step every two strobes, 0: every strobe |
| soft_en | input | 1 | 1: step-by-step ramp, 0: jump to goal |
| pdn_req | input | 1 | Request to ramp to mute and power down |
| gain_code | output | 7 | Applied gain code (0 while muted) |
| muted | output | 1 | Applied gain is in the mute state |
| at_target | output | 1 | Applied gain equals the target |
| pdn_done | output | 1 | Channel has reached mute under a power-down request |

## Verification
The bench checks the boundary between code 0 and mute in both directions. A design that treats mute as code 0 would report unmuted too early, or would never mute during power-down. It reverses the target partway through a ramp and checks for overshoot. A step direction latched at ramp start would carry the gain past the new target. In two-strobe mode it strobes while the gain already sits at the target, then moves the target by one code. A counter that kept counting while idle would take that step one strobe too early. It also holds the power-down request long after mute is reached. A powered-down flag that dropped on its own, or a ramp that restarted early, would show up there.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  localparam int CODE_MAX = 119;
  localparam int CODE_W   = $clog2(CODE_MAX + 1);

  typedef struct packed {
    logic              mute;
    logic [CODE_W-1:0] code;
  } gain_state_t;
endpackage

// File: rtl/ramp_goal_sel.sv
module ramp_goal_sel
  import gain_ramp_pkg::*;
#(
  parameter int MAX_CODE = CODE_MAX,
  parameter int W        = CODE_W
) (
  input  logic [W-1:0] target_code,
  input  logic         pdn_req,
  output logic [W-1:0] tgt_clamped,
  output gain_state_t  goal
);
  localparam logic [W-1:0] MAX_V = W'(MAX_CODE);

  always_comb begin
    tgt_clamped = (target_code > MAX_V) ? MAX_V : target_code;
    if (pdn_req) begin
      goal.mute = 1'b1;
      goal.code = '0;
    end else begin
      goal.mute = 1'b0;
      goal.code = tgt_clamped;
    end
  end
endmodule

// File: rtl/ramp_pacer.sv
module ramp_pacer (
  input  logic clk,
  input  logic rst,
  input  logic sample_stb,
  input  logic interval_two,
  input  logic soft_en,
  input  logic at_goal,
  output logic fire
);
  logic half_done;

  always_comb begin
    fire = sample_stb && !at_goal &&
           (!soft_en || !interval_two || half_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_done <= 1'b0;
    end else if (at_goal || !soft_en || !interval_two) begin
      half_done <= 1'b0;
    end else if (sample_stb) begin
      half_done <= ~half_done;
    end
  end

  // R4: in two-strobe mode no step follows a strobe whose pair counter was empty
  assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (soft_en && interval_two && sample_stb && !half_done) |-> !fire);
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
  import gain_ramp_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic        clk,
  input  logic        rst,
  input  gain_state_t goal,
  input  logic        soft_en,
  input  logic        fire,
  output logic        at_goal,
  output gain_state_t st,
  output gain_state_t st_nxt
);
  gain_state_t one_step;

  always_comb begin
    at_goal  = (st == goal);
    one_step = st;
    if (st.mute) begin
      one_step.mute = 1'b0;
      one_step.code = '0;
    end else if (goal.mute) begin
      if (st.code == '0) begin
        one_step.mute = 1'b1;
      end else begin
        one_step.code = st.code - 1'b1;
      end
    end else if (st.code < goal.code) begin
      one_step.code = st.code + 1'b1;
    end else begin
      one_step.code = st.code - 1'b1;
    end

    if (!fire)        st_nxt = st;
    else if (soft_en) st_nxt = one_step;
    else              st_nxt = goal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st.mute <= 1'b1;
      st.code <= '0;
    end else begin
      st <= st_nxt;
    end
  end

  // R3: applied gain holds when no sample strobe arrives
  assert_hold_without_fire_R3: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(st));

  // R3: a soft step between two unmuted states changes the code by at most one
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (soft_en && !st.mute) |=> (st.mute ||
      (($past(st.code) >= st.code) ? ($past(st.code) - st.code) : (st.code - $past(st.code))) <= 1));

  // R5: leaving mute by a soft step always lands on code 0
  assert_unmute_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (soft_en && st.mute) |=> (st.mute || st.code == '0));

  // R5: muted state always presents code 0
  assert_mute_code_zero_R5: assert property (@(posedge clk) disable iff (rst)
    st.mute |-> st.code == '0);
endmodule

// File: rtl/ramp_status.sv
module ramp_status
  import gain_ramp_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic        clk,
  input  logic        rst,
  input  gain_state_t st,
  input  gain_state_t st_nxt,
  input  logic [W-1:0] tgt_clamped,
  input  logic        pdn_req,
  output logic        at_target,
  output logic        pdn_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      at_target <= 1'b0;
      pdn_done  <= 1'b0;
    end else begin
      at_target <= !st_nxt.mute && (st_nxt.code == tgt_clamped);
      pdn_done  <= pdn_req && st.mute;
    end
  end

  // R7: the powered-down report only ever accompanies mute
  assert_done_only_muted_R7: assert property (@(posedge clk) disable iff (rst)
    pdn_done |-> st.mute);

  // R8: the reached flag is never raised while muted
  assert_target_not_muted_R8: assert property (@(posedge clk) disable iff (rst)
    at_target |-> !st.mute);
endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int MAX_CODE = CODE_MAX,
  parameter int W        = CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] target_code,
  input  logic         sample_stb,
  input  logic         interval_two,
  input  logic         soft_en,
  input  logic         pdn_req,
  output logic [W-1:0] gain_code,
  output logic         muted,
  output logic         at_target,
  output logic         pdn_done
);
  gain_state_t  goal, st, st_nxt;
  logic [W-1:0] tgt_clamped;
  logic         at_goal, fire;

  ramp_goal_sel #(.MAX_CODE(MAX_CODE), .W(W)) u_goal (
    .target_code(target_code), .pdn_req(pdn_req),
    .tgt_clamped(tgt_clamped), .goal(goal));

  ramp_pacer u_pacer (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .interval_two(interval_two),
    .soft_en(soft_en), .at_goal(at_goal), .fire(fire));

  ramp_stepper #(.W(W)) u_step (
    .clk(clk), .rst(rst), .goal(goal), .soft_en(soft_en), .fire(fire),
    .at_goal(at_goal), .st(st), .st_nxt(st_nxt));

  ramp_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .st(st), .st_nxt(st_nxt), .tgt_clamped(tgt_clamped),
    .pdn_req(pdn_req), .at_target(at_target), .pdn_done(pdn_done));

  assign gain_code = st.code;
  assign muted     = st.mute;

  // R1: applied code never leaves the legal range
  assert_code_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    gain_code <= W'(MAX_CODE));
endmodule

// File: tb/test_gain_ramp_ctrl.sv
module test_gain_ramp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] target_code = '0;
  logic       sample_stb = 1'b0, interval_two = 1'b0, soft_en = 1'b1, pdn_req = 1'b0;
  logic [6:0] gain_code;
  logic       muted, at_target, pdn_done;

  int n_chk = 0;
  int n_bad = 0;

  gain_ramp_ctrl i_gain_ramp_ctrl (
    .clk(clk), .rst(rst), .target_code(target_code), .sample_stb(sample_stb),
    .interval_two(interval_two), .soft_en(soft_en), .pdn_req(pdn_req),
    .gain_code(gain_code), .muted(muted), .at_target(at_target), .pdn_done(pdn_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: soft, two, target[7], strobes[4], exp code[7], exp mute, exp at_target
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 7'd5,   4'd3, 7'd2,   1'b0, 1'b0},  // R3, R5 from mute
    {1'b1, 1'b0, 7'd5,   4'd3, 7'd5,   1'b0, 1'b1},  // R3
    {1'b1, 1'b0, 7'd5,   4'd2, 7'd5,   1'b0, 1'b1},  // R3 holds at target
    {1'b1, 1'b1, 7'd3,   4'd2, 7'd4,   1'b0, 1'b0},  // R4
    {1'b1, 1'b1, 7'd3,   4'd2, 7'd3,   1'b0, 1'b1},  // R4
    {1'b0, 1'b0, 7'd100, 4'd1, 7'd100, 1'b0, 1'b1},  // R6
    {1'b0, 1'b0, 7'd127, 4'd1, 7'd119, 1'b0, 1'b1},  // R1 clamp
    {1'b1, 1'b0, 7'd0,   4'd3, 7'd116, 1'b0, 1'b0}   // R3 downward
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R2 muted", 7'(muted), 7'd1);
    check("R2 code", gain_code, 7'd0);
    check("R2 at_target", 7'(at_target), 7'd0);
    check("R2 pdn_done", 7'(pdn_done), 7'd0);

    for (int v = 0; v < NVEC; v++) begin
      soft_en      = VEC[v][21];
      interval_two = VEC[v][20];
      target_code  = VEC[v][19:13];
      strobe(int'(VEC[v][12:9]));
      check($sformatf("R1/R3/R4/R6 vec%0d code", v), gain_code, VEC[v][8:2]);
      check($sformatf("R5 vec%0d mute", v), 7'(muted), 7'(VEC[v][1]));
      check($sformatf("R8 vec%0d at_target", v), 7'(at_target), 7'(VEC[v][0]));
    end

    // R3: no strobe, no change
    target_code = 7'd50; idle(6);
    check("R3 hold without strobe", gain_code, 7'd116);

    // R9: target reversal mid-ramp
    soft_en = 1'b0; target_code = 7'd10; strobe(1);
    check("R6 jump", gain_code, 7'd10);
    soft_en = 1'b1; target_code = 7'd20; strobe(3);
    check("R9 ramp up", gain_code, 7'd13);
    target_code = 7'd11; strobe(1);
    check("R9 reverse", gain_code, 7'd12);
    strobe(1);
    check("R9 reach", gain_code, 7'd11);
    check("R8 at_target", 7'(at_target), 7'd1);
    strobe(1);
    check("R9 no overshoot", gain_code, 7'd11);

    // R4: pair counter cleared while at target
    interval_two = 1'b1; strobe(1);
    target_code = 7'd12; strobe(1);
    check("R4 first strobe no step", gain_code, 7'd11);
    check("R8 not at target", 7'(at_target), 7'd0);
    strobe(1);
    check("R4 second strobe steps", gain_code, 7'd12);

    // R7 / R5: ramp into power-down
    interval_two = 1'b0; soft_en = 1'b0; target_code = 7'd2; strobe(1);
    soft_en = 1'b1; pdn_req = 1'b1; strobe(2);
    check("R5 at code 0", gain_code, 7'd0);
    check("R5 not yet muted", 7'(muted), 7'd0);
    check("R7 not done before mute", 7'(pdn_done), 7'd0);
    strobe(1);
    check("R5 step below 0 mutes", 7'(muted), 7'd1);
    idle(1);
    check("R7 done after mute", 7'(pdn_done), 7'd1);
    strobe(4);
    check("R7 held muted", 7'(muted), 7'd1);
    check("R7 held done", 7'(pdn_done), 7'd1);
    check("R8 no flag while muted", 7'(at_target), 7'd0);
    pdn_req = 1'b0; idle(2);
    check("R7 done clears", 7'(pdn_done), 7'd0);
    check("R7 still muted before strobe", 7'(muted), 7'd1);
    strobe(1);
    check("R5 unmute to 0", 7'(muted), 7'd0);
    check("R5 unmute code", gain_code, 7'd0);
    strobe(1);
    check("R7 ramp resumes", gain_code, 7'd1);

    // R6: jump into mute with soft stepping off
    soft_en = 1'b0; pdn_req = 1'b1; strobe(1);
    check("R6 jump to mute", 7'(muted), 7'd1);
    pdn_req = 1'b0; soft_en = 1'b1;

    // R2: reset in mid operation
    strobe(2);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check("R2 re-reset muted", 7'(muted), 7'd1);
    check("R2 re-reset code", gain_code, 7'd0);

    finish_run();
  end
endmodule